// File: doc/BRIEF.md
# SPI Master Word Shift Engine

This block moves one word across a SPI link in master mode. A single 32-bit format word, captured when a transfer starts, sets the word length, the serial clock divider, the clock's idle level, the sampling edge, the bit order and an optional trailing parity bit. The engine drives the serial clock and the outgoing data line and samples the incoming data line. A loopback input lets it feed its own outgoing stream back into its receiver.

A user drives `fmt_i`, `tx_word_i` and `loopback_i`, then pulses `start_i` while `busy_o` is low. `busy_o` stays high for the whole transfer. In the clock after the transfer ends, `done_o` pulses for one cycle. The received word and the parity error flag are updated on that pulse and then hold until the next `done_o`. Chip-select timing, delays between words and register access are handled by surrounding logic.

Top module: `spi_shift_engine`

## Requirements
- R1: The word length L is taken from `fmt_i[4:0]`. Values 2 to 16 are used as given, values below 2 become 2, and values above 16 become 16. Exactly L data bits are sent, plus one parity bit when parity is enabled.
- R2: Each bit period lasts D module clocks, where D = `fmt_i[15:8]` + 1. `busy_o` is high for exactly N*D clocks, where N is the bit count including parity. `done_o` is high for exactly one clock, in the clock right after `busy_o` falls.
- R3: `fmt_i[17]` sets the idle level of `sclk_o` (1 = idle high). The serial clock moves to the opposite level once per bit period and is back at its idle level after the transfer.
- R4: With `fmt_i[16]` = 1, incoming data is sampled on the first clock edge of each bit period and outgoing data is set up before that edge. With `fmt_i[16]` = 0, outgoing data changes on the first edge and incoming data is sampled on the second edge.
- R5: With `fmt_i[20]` = 0 the word is sent most significant bit first, so bit L-1 goes first. With `fmt_i[20]` = 1 bit 0 goes first. Received bits are placed into the same bit positions they occupy when sent.
- R6: With `fmt_i[22]` = 1, a parity bit follows the data bits. `fmt_i[23]` = 1 selects odd parity and 0 selects even parity, computed over the L data bits. When the received parity bit does not match the received data, `par_err_o` reads 1 from the `done_o` pulse onward.
- R7: With `loopback_i` = 1, the receiver takes its input from the outgoing stream, and `miso_i` has no effect.
- R8: `rx_word_o` holds the received L bits right-justified. Bits L and above read 0.
- R9: A `start_i` pulse while `busy_o` is high is ignored. Changes to `fmt_i` and `tx_word_i` during a transfer do not affect it.
- R10: After reset, `busy_o`, `done_o`, `mosi_o`, `par_err_o` and `rx_word_o` are 0, and while idle `sclk_o` equals `fmt_i[17]`.
- R11: A divider field that gives D below 3 is raised to D = 3. The largest field value gives D = 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 32 | Format word, captured at start |
| loopback_i | input | 1 | Route outgoing stream into receiver |
| start_i | input | 1 | Start request, taken only when idle |
| tx_word_i | input | 16 | Word to send, captured at start |
| miso_i | input | 1 | Incoming serial data |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Outgoing serial data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock pulse at transfer end |
| rx_word_o | output | 16 | Received word, right-justified |
| par_err_o | output | 1 | Parity mismatch on the last transfer |

## Verification
The two internal counters set where the clock edges fall and when a transfer ends, so an error in either one appears at once on `sclk_o`: the number of edges per transfer or the `busy_o` length in cycles is wrong. An error in the bit index or sample point shows only at the end of the word, as a `rx_word_o` value that differs from the sent word under loopback. The bench therefore counts clock edges and busy cycles and also compares whole words. The sampling edge is checked with an incoming data level tied to the serial clock's level, so sampling on the wrong edge flips every received bit.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW      = 16,
  parameter int MIN_DIV = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   fmt_i,
  input  logic          loopback_i,
  input  logic          start_i,
  input  logic [DW-1:0] tx_word_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          par_err_o
);
  localparam int LW = $clog2(DW + 2);
  localparam int IW = $clog2(DW);

  logic          busy_q, done_q, par_err_q, rx_par_q;
  logic          cpha0_q, cpol_q, lsb_q, pen_q, podd_q;
  logic [LW-1:0] len_q, bit_q;
  logic [8:0]    div_q, cnt_q;
  logic [DW-1:0] tx_q, rx_q, rx_word_q;

  logic [LW-1:0] len_in;
  logic [8:0]    div_raw, div_in;
  logic unused_fmt;
  assign unused_fmt = ^{fmt_i[31:24], fmt_i[21], fmt_i[19:18], fmt_i[7:5]};

  always_comb begin
    if (fmt_i[4:0] < 5'd2)       len_in = LW'(2);
    else if (fmt_i[4:0] > 5'(DW)) len_in = LW'(DW);
    else                          len_in = LW'(fmt_i[4:0]);
  end
  assign div_raw = {1'b0, fmt_i[15:8]} + 9'd1;
  assign div_in  = (div_raw < 9'(MIN_DIV)) ? 9'(MIN_DIV) : div_raw;

  logic [8:0]    half, lead;
  logic [LW-1:0] nbits, pos;
  logic [DW:0]   one_sh;
  logic [DW-1:0] mask;
  logic          in_data, tx_par, tx_bit, act, sample_now, miso_eff, slot_end;

  assign half     = div_q >> 1;
  assign lead     = div_q - half;
  assign nbits    = len_q + LW'(pen_q);
  assign one_sh   = (DW+1)'(1) << len_q;
  assign mask     = one_sh[DW-1:0] - 1'b1;
  assign in_data  = bit_q < len_q;
  assign pos      = lsb_q ? bit_q : (len_q - LW'(1) - bit_q);
  assign tx_par   = podd_q ^ (^(tx_q & mask));
  assign tx_bit   = in_data ? tx_q[pos[IW-1:0]] : tx_par;
  assign mosi_o   = busy_q & tx_bit;
  assign act      = cpha0_q ? (cnt_q >= lead) : (cnt_q < half);
  assign sclk_o   = busy_q ? (cpol_q ^ act) : fmt_i[17];
  assign sample_now = busy_q && (cnt_q == (cpha0_q ? lead : half) - 9'd1);
  assign miso_eff = loopback_i ? mosi_o : miso_i;
  assign slot_end = cnt_q == div_q - 9'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; par_err_q <= 1'b0; rx_par_q <= 1'b0;
      cpha0_q <= 1'b0; cpol_q <= 1'b0; lsb_q <= 1'b0; pen_q <= 1'b0; podd_q <= 1'b0;
      len_q <= LW'(2); bit_q <= '0; div_q <= 9'(MIN_DIV); cnt_q <= '0;
      tx_q <= '0; rx_q <= '0; rx_word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          len_q   <= len_in;
          div_q   <= div_in;
          cpha0_q <= fmt_i[16];
          cpol_q  <= fmt_i[17];
          lsb_q   <= fmt_i[20];
          pen_q   <= fmt_i[22];
          podd_q  <= fmt_i[23];
          tx_q    <= tx_word_i;
          cnt_q   <= '0;
          bit_q   <= '0;
          rx_q    <= '0;
          rx_par_q <= 1'b0;
        end
      end else begin
        if (sample_now) begin
          if (in_data) rx_q[pos[IW-1:0]] <= miso_eff;
          else         rx_par_q <= miso_eff;
        end
        if (slot_end) begin
          cnt_q <= '0;
          if (bit_q == nbits - LW'(1)) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            rx_word_q <= rx_q;
            par_err_q <= pen_q & (rx_par_q != (podd_q ^ (^rx_q)));
          end else begin
            bit_q <= bit_q + LW'(1);
          end
        end else begin
          cnt_q <= cnt_q + 9'd1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_word_q;
  assign par_err_o = par_err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q); // R2
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mosi_o); // R10
  AST_RX_RIGHT_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((rx_word_q & ~mask) == '0)); // R8
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(tx_q) && $stable(len_q) && $stable(div_q)); // R9
  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < div_q) && (div_q >= 9'(MIN_DIV))); // R11
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fmt_drv = 32'h0;
  logic        lp_drv = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tx_drv = 16'h0;
  logic        miso_drv = 1'b0;
  logic        probe = 1'b0;
  logic        miso, sclk, mosi, busy, done, perr;
  logic [15:0] rx;

  always #10 clk = ~clk;

  assign miso = probe ? (sclk ^ fmt_drv[17]) : miso_drv;

  spi_shift_engine u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_drv), .loopback_i(lp_drv),
    .start_i(start), .tx_word_i(tx_drv), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .busy_o(busy), .done_o(done),
    .rx_word_o(rx), .par_err_o(perr)
  );

  int total = 0, fails = 0, cyc = 0;
  int nb, busy_cnt, done_cnt;
  logic mon_en = 1'b0, prev_sclk, idle_lvl;
  logic [16:0] got_bits;
  logic [15:0] got_rx;
  logic got_perr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) if (mon_en) begin
    if (busy) busy_cnt++;
    if (done) done_cnt++;
    if (sclk != idle_lvl && prev_sclk == idle_lvl) begin
      if (nb < 17) got_bits[nb] = mosi;
      nb++;
    end
    prev_sclk = sclk;
  end

  function automatic int e_len(logic [31:0] f);
    int l = int'(f[4:0]);
    if (l < 2) l = 2;
    if (l > 16) l = 16;
    return l;
  endfunction
  function automatic int e_div(logic [31:0] f);
    int d = int'(f[15:8]) + 1;
    if (d < 3) d = 3;
    return d;
  endfunction
  function automatic int e_n(logic [31:0] f);
    return e_len(f) + int'(f[22]);
  endfunction
  function automatic logic [15:0] e_mask(logic [31:0] f);
    return 16'((32'h1 << e_len(f)) - 1);
  endfunction
  function automatic logic [16:0] e_bits(logic [31:0] f, logic [15:0] tx);
    logic [16:0] e = '0;
    int l = e_len(f);
    for (int b = 0; b < l; b++) e[b] = f[20] ? tx[b] : tx[l-1-b];
    if (f[22]) e[l] = f[23] ^ (^(tx & e_mask(f)));
    return e;
  endfunction
  function automatic logic [31:0] mk(int len, int pre, bit cpha, bit cpol, bit lsb, bit pen, bit podd);
    return 32'(len & 31) | (32'(pre & 255) << 8) | (32'(!cpha) << 16) | (32'(cpol) << 17)
         | (32'(lsb) << 20) | (32'(pen) << 22) | (32'(podd) << 23);
  endfunction

  task automatic xfer(input logic [31:0] f, input logic [15:0] tx, input bit lp, input bit poke);
    int k = 0;
    fmt_drv = f; tx_drv = tx; lp_drv = lp;
    @(negedge clk);
    nb = 0; busy_cnt = 0; done_cnt = 0; got_bits = '0;
    idle_lvl = f[17]; prev_sclk = f[17]; mon_en = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && k < 100000) begin
      if (poke && k == 5) begin start = 1'b1; tx_drv = ~tx; fmt_drv = f ^ 32'h0010_0F06; end
      if (poke && k == 6) begin start = 1'b0; fmt_drv = f; tx_drv = tx; end
      @(negedge clk);
      k++;
    end
    got_rx = rx; got_perr = perr;
    @(negedge clk);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  task automatic check_std(input string tag, input logic [31:0] f, input logic [15:0] tx, input logic [15:0] exp_rx);
    logic [16:0] m = 17'((33'h1 << e_n(f)) - 1);
    chk(nb == e_n(f), {tag, " R1 R3 sclk edges"}, nb, e_n(f));
    chk((got_bits & m) == e_bits(f, tx), {tag, " R5 R6 mosi bits"}, got_bits, e_bits(f, tx));
    chk(busy_cnt == e_n(f) * e_div(f), {tag, " R2 busy cycles"}, busy_cnt, e_n(f) * e_div(f));
    chk(done_cnt == 1, {tag, " R2 done width"}, done_cnt, 1);
    chk(got_rx == exp_rx, {tag, " R7 R8 rx word"}, got_rx, exp_rx);
    chk(sclk == f[17], {tag, " R3 idle sclk"}, sclk, f[17]);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && mosi == 0, "R10 reset controls", {busy, done, mosi}, 0);
    chk(rx == 0 && perr == 0, "R10 reset rx", {perr, rx}, 0);
    chk(sclk == fmt_drv[17], "R10 idle sclk", sclk, fmt_drv[17]);
  endtask

  task automatic t_msb_loop();
    logic [31:0] f = mk(8, 3, 0, 0, 0, 0, 0);
    xfer(f, 16'h12A5, 1, 0);
    check_std("msb", f, 16'h12A5, 16'h00A5);
    chk(got_perr == 0, "R6 no parity no error", got_perr, 0);
  endtask

  task automatic t_lsb_cpol();
    logic [31:0] f = mk(12, 4, 1, 1, 1, 0, 0);
    xfer(f, 16'h03C6, 1, 0);
    check_std("lsb cpol1", f, 16'h03C6, 16'h03C6);
  endtask

  task automatic t_parity();
    logic [31:0] f = mk(9, 2, 0, 0, 0, 1, 0);
    xfer(f, 16'h01F3, 1, 0);
    check_std("even par", f, 16'h01F3, 16'h01F3);
    chk(got_perr == 0, "R6 even loop no error", got_perr, 0);
    f = mk(16, 2, 1, 0, 1, 1, 1);
    xfer(f, 16'hFFFF, 1, 0);
    check_std("odd par", f, 16'hFFFF, 16'hFFFF);
    chk(got_perr == 0, "R6 odd loop no error", got_perr, 0);
  endtask

  task automatic t_parity_err();
    logic [31:0] f = mk(8, 2, 0, 0, 0, 1, 0);
    miso_drv = 1'b1;
    xfer(f, 16'h0000, 0, 0);
    chk(got_rx == 16'h00FF, "R7 R8 miso ones len8", got_rx, 16'h00FF);
    chk(got_perr == 1, "R6 even mismatch", got_perr, 1);
    f = mk(7, 2, 0, 0, 0, 1, 0);
    xfer(f, 16'h0000, 0, 0);
    chk(got_rx == 16'h007F, "R8 miso ones len7", got_rx, 16'h007F);
    chk(got_perr == 0, "R6 even match", got_perr, 0);
    miso_drv = 1'b0;
    xfer(f, 16'h0055, 1, 0);
    chk(got_rx == 16'h0055, "R7 loopback ignores miso", got_rx, 16'h0055);
  endtask

  task automatic t_phase();
    logic [31:0] f = mk(10, 5, 0, 0, 0, 0, 0);
    probe = 1'b1;
    xfer(f, 16'h0000, 0, 0);
    chk(got_rx == 16'h0000, "R4 first-edge sample", got_rx, 0);
    f = mk(10, 5, 1, 1, 0, 0, 0);
    xfer(f, 16'h0000, 0, 0);
    chk(got_rx == 16'h03FF, "R4 second-edge sample", got_rx, 16'h03FF);
    probe = 1'b0;
  endtask

  task automatic t_clamp();
    logic [31:0] f = mk(5, 0, 0, 0, 0, 0, 0);
    xfer(f, 16'h0013, 1, 0);
    check_std("div floor pre0 R11", f, 16'h0013, 16'h0013);
    f = mk(5, 1, 1, 0, 0, 0, 0);
    xfer(f, 16'h000A, 1, 0);
    check_std("div floor pre1 R11", f, 16'h000A, 16'h000A);
    f = mk(2, 255, 0, 1, 0, 0, 0);
    xfer(f, 16'h0002, 1, 0);
    check_std("div max R11", f, 16'h0002, 16'h0002);
    f = mk(1, 2, 0, 0, 0, 0, 0);
    xfer(f, 16'h0003, 1, 0);
    check_std("len floor R1", f, 16'h0003, 16'h0003);
    f = mk(31, 2, 0, 0, 1, 0, 0);
    xfer(f, 16'hBEEF, 1, 0);
    check_std("len ceil R1", f, 16'hBEEF, 16'hBEEF);
  endtask

  task automatic t_upper_zero();
    logic [31:0] f = mk(4, 2, 0, 0, 1, 0, 0);
    xfer(f, 16'hFFFF, 1, 0);
    check_std("upper zero R8", f, 16'hFFFF, 16'h000F);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] f = mk(8, 3, 0, 0, 0, 0, 0);
    xfer(f, 16'h00C3, 1, 1);
    check_std("busy start R9", f, 16'h00C3, 16'h00C3);
    @(negedge clk);
    chk(busy == 0, "R9 no second transfer", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msb_loop();
    t_lsb_cpol();
    t_parity();
    t_parity_err();
    t_phase();
    t_clamp();
    t_upper_zero();
    t_busy_ignore();
    finish_run();
  end
endmodule